// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block gathers interrupt events for a small 8-bit processor core and turns them into a single vectored call. It has five interrupt sources: timer 0, timer 1, a source shared by timer 2 and the UART, an RC-oscillator converter overflow, and an ADPCM source. The ADPCM source merges two channel buffer-empty events. Each event pulse sets a sticky request flag. The flags, the per-source enable bits and the master enable live in two 8-bit control registers. Software reads those registers back and can also write them.

When the master enable is set, the core reports that its return stack has room, and a source is both flagged and enabled, the block raises a call request with the vector address of the winning source. The core takes the call with a one-cycle acknowledge. The call request behaves as a valid/ready pair. Once `call_req` rises, `call_req` and `call_vec` stay unchanged until the cycle in which `call_ack` is high. The block never drops or changes a request on its own. On that handshake the block clears the serviced flag or flags and the master enable. A return-with-enable strobe from the core sets the master enable again. A separate wake output tells the core that an enabled request is pending, so that it can leave power-down.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both control registers read 0x00, `call_req` is low and `wake` is low. Control register A (`reg_sel`=0) holds these bits: bit0 master enable, bit2 timer 0 enable, bit3 timer 1 enable, bit4 RC enable, bit5 timer 0 flag, bit6 timer 1 flag, bit7 ADPCM enable. Control register B (`reg_sel`=1) holds these bits: bit0 timer 2/UART enable, bit3 channel 0 flag, bit4 timer 2/UART flag, bit5 RC flag, bit6 ADPCM summary flag, bit7 channel 1 flag. Bits not named here read 0.
- R2: A call is taken only when the master enable is 1, `stack_full` is 0, and at least one source is both flagged and enabled. `call_req` goes high on the clock edge after the one at which all three conditions hold.
- R3: `call_vec` is 0x08 for timer 0, 0x0C for timer 1, 0x10 for timer 2/UART, 0x14 for RC and 0x18 for ADPCM. It reads 0x00 while `call_req` is low.
- R4: When several sources are flagged and enabled, the lowest vector address wins.
- R5: `call_req` and `call_vec` hold until `call_ack` is sampled high. At that edge `call_req` falls, the serviced source's flag clears and the master enable clears.
- R6: A flag stays set after its enable bit is cleared. It clears only when its source is serviced or when software writes 0 to it.
- R7: When an event pulse and a clear of the same flag happen in the same cycle, the flag ends up set. The clear can be a software write of 0 or a service.
- R8: A channel 0 or channel 1 empty event sets that channel's flag and the ADPCM summary flag at the same edge. Servicing the ADPCM vector clears all three flags.
- R9: `wake` is high exactly when some flag is set together with its enable bit. The master enable and `stack_full` have no effect on it.
- R10: A `reti_en` pulse sets the master enable.
- R11: A software write loads every defined bit of the selected register, so writing 1 to a flag sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_tmr0 | input | 1 | Timer 0 overflow pulse |
| evt_tmr1 | input | 1 | Timer 1 overflow pulse |
| evt_tmr2_uart | input | 1 | Timer 2 overflow or UART event pulse |
| evt_rcosc | input | 1 | RC-oscillator converter overflow pulse |
| evt_ch0_empty | input | 1 | ADPCM channel 0 buffer-empty pulse |
| evt_ch1_empty | input | 1 | ADPCM channel 1 buffer-empty pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control register A, 1 selects B |
| reg_wdata | input | DW | Write data |
| ctrl_a_q | output | DW | Control register A read value |
| ctrl_b_q | output | DW | Control register B read value |
| stack_full | input | 1 | Core return stack has no free entry |
| reti_en | input | 1 | Return-with-enable strobe, sets master enable |
| call_req | output | 1 | Vectored call request (valid) |
| call_vec | output | VEC_W | Vector address of the pending call |
| call_ack | input | 1 | Core takes the call (ready) |
| wake | output | 1 | Enabled request pending, wake from power-down |

## Verification
The bench sweeps all 31 non-empty flag sets with every source enabled and serves each set one call at a time. A wrong priority order or a wrong vector formula would produce a vector sequence that differs from the one computed bit by bit. It sweeps all 32 enable masks with every flag set and `stack_full` high, which catches a design that ignores the stack gate or lets `wake` depend on the master enable. Directed cases aim an event at the same edge as a software clear, and then at the same edge as a service. There a design that gives the clear priority would lose the event. The ADPCM case checks that one service clears both channel flags together with the summary flag.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC  = 5;
  localparam int NFLAG = 7;
  localparam int SIW   = $clog2(NSRC);

  // source index, also flag index for the first NSRC flags
  localparam int SRC_T0  = 0;
  localparam int SRC_T1  = 1;
  localparam int SRC_T2  = 2;
  localparam int SRC_RC  = 3;
  localparam int SRC_ADP = 4;
  // extra per-channel flags
  localparam int FL_CH0  = 5;
  localparam int FL_CH1  = 6;
endpackage

// File: rtl/irqc_flag.sv
module irqc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic svc_clr,
  input  logic sw_wr,
  input  logic sw_val,
  output logic q
);
  // an event always wins, so no pulse is ever lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (hw_set)  q <= 1'b1;
    else if (svc_clr) q <= 1'b0;
    else if (sw_wr)   q <= sw_val;
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = i[IW-1:0];
    end
  end
endmodule

// File: rtl/irqc_call.sv
module irqc_call #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [IW-1:0] take_idx,
  input  logic          call_ack,
  output logic          call_req,
  output logic [IW-1:0] call_idx,
  output logic          fire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_req <= 1'b0;
      call_idx <= '0;
    end else if (call_req) begin
      if (call_ack) call_req <= 1'b0;
    end else if (take) begin
      call_req <= 1'b1;
      call_idx <= take_idx;
    end
  end

  assign fire = call_req & call_ack;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int DW       = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 8,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_tmr0,
  input  logic             evt_tmr1,
  input  logic             evt_tmr2_uart,
  input  logic             evt_rcosc,
  input  logic             evt_ch0_empty,
  input  logic             evt_ch1_empty,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    ctrl_a_q,
  output logic [DW-1:0]    ctrl_b_q,
  input  logic             stack_full,
  input  logic             reti_en,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  input  logic             call_ack,
  output logic             wake
);
  logic             wr_a, wr_b;
  logic             emi_q;
  logic [NSRC-1:0]  en_q;
  logic [NFLAG-1:0] fl_q, hw_set, svc_clr, sw_wr, sw_val;
  logic [NSRC-1:0]  live;
  logic             any_live, take, fire;
  logic [SIW-1:0]   win_idx, call_idx;
  logic             unused_wdata;

  assign wr_a = reg_wr & ~reg_sel;
  assign wr_b = reg_wr &  reg_sel;
  assign unused_wdata = reg_wdata[1];

  // master enable: service clears, return strobe sets, then software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       emi_q <= 1'b0;
    else if (fire)    emi_q <= 1'b0;
    else if (reti_en) emi_q <= 1'b1;
    else if (wr_a)    emi_q <= reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      if (wr_a) begin
        en_q[SRC_T0]  <= reg_wdata[2];
        en_q[SRC_T1]  <= reg_wdata[3];
        en_q[SRC_RC]  <= reg_wdata[4];
        en_q[SRC_ADP] <= reg_wdata[7];
      end
      if (wr_b) en_q[SRC_T2] <= reg_wdata[0];
    end
  end

  // event, write and service wiring per flag
  always_comb begin
    hw_set[SRC_T0]  = evt_tmr0;
    hw_set[SRC_T1]  = evt_tmr1;
    hw_set[SRC_T2]  = evt_tmr2_uart;
    hw_set[SRC_RC]  = evt_rcosc;
    hw_set[SRC_ADP] = evt_ch0_empty | evt_ch1_empty;
    hw_set[FL_CH0]  = evt_ch0_empty;
    hw_set[FL_CH1]  = evt_ch1_empty;

    sw_wr  = {wr_b, wr_b, wr_b, wr_b, wr_b, wr_a, wr_a};
    sw_val[SRC_T0]  = reg_wdata[5];
    sw_val[SRC_T1]  = reg_wdata[6];
    sw_val[SRC_T2]  = reg_wdata[4];
    sw_val[SRC_RC]  = reg_wdata[5];
    sw_val[SRC_ADP] = reg_wdata[6];
    sw_val[FL_CH0]  = reg_wdata[3];
    sw_val[FL_CH1]  = reg_wdata[7];
  end

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    localparam int SVC = (k < NSRC) ? k : SRC_ADP;
    assign svc_clr[k] = fire && (call_idx == SIW'(SVC));
    irqc_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (hw_set[k]),
      .svc_clr (svc_clr[k]),
      .sw_wr   (sw_wr[k]),
      .sw_val  (sw_val[k]),
      .q       (fl_q[k])
    );
  end

  assign live = fl_q[NSRC-1:0] & en_q;
  assign wake = |live;

  irqc_prio #(.N(NSRC), .IW(SIW)) u_prio (
    .req (live),
    .any (any_live),
    .idx (win_idx)
  );

  assign take = emi_q & ~stack_full & any_live;

  irqc_call #(.IW(SIW)) u_call (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_idx (win_idx),
    .call_ack (call_ack),
    .call_req (call_req),
    .call_idx (call_idx),
    .fire     (fire)
  );

  assign call_vec = call_req ?
      VEC_W'(VEC_BASE) + VEC_W'(call_idx) * VEC_W'(VEC_STEP) : '0;

  always_comb begin
    ctrl_a_q    = '0;
    ctrl_a_q[0] = emi_q;
    ctrl_a_q[2] = en_q[SRC_T0];
    ctrl_a_q[3] = en_q[SRC_T1];
    ctrl_a_q[4] = en_q[SRC_RC];
    ctrl_a_q[5] = fl_q[SRC_T0];
    ctrl_a_q[6] = fl_q[SRC_T1];
    ctrl_a_q[7] = en_q[SRC_ADP];

    ctrl_b_q    = '0;
    ctrl_b_q[0] = en_q[SRC_T2];
    ctrl_b_q[3] = fl_q[FL_CH0];
    ctrl_b_q[4] = fl_q[SRC_T2];
    ctrl_b_q[5] = fl_q[SRC_RC];
    ctrl_b_q[6] = fl_q[SRC_ADP];
    ctrl_b_q[7] = fl_q[FL_CH1];
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int DW    = 8,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_tmr0,
  input logic             evt_ch0_empty,
  input logic             stack_full,
  input logic             call_req,
  input logic             call_ack,
  input logic [VEC_W-1:0] call_vec,
  input logic [DW-1:0]    ctrl_a_q,
  input logic [DW-1:0]    ctrl_b_q,
  input logic             wake
);
  p_accept_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_req) |-> $past(ctrl_a_q[0] && !stack_full));

  p_vec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec == 8'h08 || call_vec == 8'h0C || call_vec == 8'h10 ||
                  call_vec == 8'h14 || call_vec == 8'h18));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !call_ack) |=> (call_req && $stable(call_vec)));

  p_ack_emi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && call_ack) |=> (!call_req && !ctrl_a_q[0]));

  p_hw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tmr0 |=> ctrl_a_q[5]);

  p_adp_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ch0_empty |=> (ctrl_b_q[3] && ctrl_b_q[6]));

  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_a_q[2] && ctrl_a_q[5]) |-> wake);
endmodule

bind irq_vector_ctrl irqc_chk #(.DW(DW), .VEC_W(VEC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt_tmr0      (evt_tmr0),
  .evt_ch0_empty (evt_ch0_empty),
  .stack_full    (stack_full),
  .call_req      (call_req),
  .call_ack      (call_ack),
  .call_vec      (call_vec),
  .ctrl_a_q      (ctrl_a_q),
  .ctrl_b_q      (ctrl_b_q),
  .wake          (wake)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic       clk = 0, rst_n = 0;
  logic       evt_tmr0 = 0, evt_tmr1 = 0, evt_tmr2_uart = 0, evt_rcosc = 0;
  logic       evt_ch0_empty = 0, evt_ch1_empty = 0;
  logic       reg_wr = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] ctrl_a_q, ctrl_b_q, call_vec;
  logic       stack_full = 0, reti_en = 0, call_ack = 0, call_req, wake;
  int         n_chk = 0, n_err = 0;
  bit         done = 0;

  irq_vector_ctrl u_dut (.*);

  always #10 clk = ~clk;

  // en: {adp, rc, t2, t1, t0}; fl: {ch1, ch0, adp, rc, t2, t1, t0}
  function automatic [7:0] pk_a(bit emi, bit [4:0] en, bit [6:0] fl);
    return {en[4], fl[1], fl[0], en[3], en[1], en[0], 1'b0, emi};
  endfunction
  function automatic [7:0] pk_b(bit [4:0] en, bit [6:0] fl);
    return {fl[6], fl[4], fl[3], fl[2], fl[5], 2'b00, en[2]};
  endfunction
  function automatic int lowbit(bit [4:0] m);
    for (int i = 0; i < 5; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask
  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask
  task automatic wr(bit sel, logic [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    chk("R1 reset ctrl_a", ctrl_a_q, 0);
    chk("R1 reset ctrl_b", ctrl_b_q, 0);
    chk("R1 reset call_req", call_req, 0);
    chk("R1 reset wake", wake, 0);

    // sweep 1: all flag sets, all enables, served one at a time
    for (int m = 1; m < 32; m++) begin
      bit [6:0] fl = {2'b00, m[4:0]};
      bit [4:0] rem = m[4:0];
      wr(0, 8'h00);
      wr(1, pk_b(5'h1f, fl));
      wr(0, pk_a(1, 5'h1f, fl));
      chk("R11 write ctrl_a", ctrl_a_q, pk_a(1, 5'h1f, fl));
      chk("R1 layout ctrl_b", ctrl_b_q, pk_b(5'h1f, fl));
      chk("R2 no call before next edge", call_req, 0);
      while (rem != 0) begin
        int k = lowbit(rem);
        step();
        chk("R4 call raised", call_req, 1);
        chk("R3 vector", call_vec, 8 + 4 * k);
        step();
        chk("R5 hold req", call_req, 1);
        chk("R5 hold vec", call_vec, 8 + 4 * k);
        call_ack = 1; step(); call_ack = 0;
        rem[k] = 0; fl[k] = 0;
        chk("R5 req falls", call_req, 0);
        chk("R5 flag and emi clear a", ctrl_a_q, pk_a(0, 5'h1f, fl));
        chk("R5 flag clear b", ctrl_b_q, pk_b(5'h1f, fl));
        reti_en = 1; step(); reti_en = 0;
        chk("R10 reti sets emi", ctrl_a_q[0], 1);
      end
      step();
      chk("R2 idle when none pending", call_req, 0);
    end

    // sweep 2: all enable masks, all flags, stack full gate
    for (int e = 0; e < 32; e++) begin
      bit [4:0] en = e[4:0];
      wr(0, 8'h00);
      wr(1, pk_b(en, 7'h1f));
      chk("R9 wake without emi", wake, en[2]);
      stack_full = 1;
      wr(0, pk_a(1, en, 7'h1f));
      step(); step();
      chk("R2 stack full blocks", call_req, 0);
      chk("R9 wake ignores stack", wake, (en != 0) ? 1 : 0);
      stack_full = 0;
      step(); step();
      chk("R2 call after stack frees", call_req, (en != 0) ? 1 : 0);
      if (en != 0) begin
        chk("R4 enable masked priority", call_vec, 8 + 4 * lowbit(en));
        call_ack = 1; step(); call_ack = 0;
      end
      wr(0, 8'h00);
      wr(1, 8'h00);
    end

    // R6: flag persists after enable cleared
    wr(0, pk_a(0, 5'b00010, 7'h00));
    evt_tmr1 = 1; step(); evt_tmr1 = 0;
    chk("R6 event sets flag", ctrl_a_q[6], 1);
    wr(0, pk_a(0, 5'b00000, 7'b0000010));
    step(); step();
    chk("R6 flag kept w/o enable", ctrl_a_q[6], 1);
    chk("R6 wake low w/o enable", wake, 0);
    wr(0, 8'h00);
    chk("R6 sw zero clears", ctrl_a_q[6], 0);

    // R7: event versus software clear
    wr(0, pk_a(0, 5'b0, 7'b0000001));
    evt_tmr0 = 1; wr(0, 8'h00); evt_tmr0 = 0;
    chk("R7 event beats sw clear", ctrl_a_q[5], 1);
    // R7: event versus service clear
    wr(0, pk_a(1, 5'b00001, 7'b0000001));
    step();
    chk("R7 call for t0", call_vec, 8'h08);
    call_ack = 1; evt_tmr0 = 1; step(); call_ack = 0; evt_tmr0 = 0;
    chk("R7 event beats service", ctrl_a_q, pk_a(0, 5'b00001, 7'b0000001));
    wr(0, 8'h00);

    // R8: ADPCM merge
    evt_ch1_empty = 1; step(); evt_ch1_empty = 0;
    chk("R8 ch1 event", ctrl_b_q, 8'hC0);
    evt_ch0_empty = 1; step(); evt_ch0_empty = 0;
    chk("R8 ch0 event", ctrl_b_q, 8'hC8);
    wr(0, pk_a(1, 5'b10000, 7'h00));
    step();
    chk("R8 adpcm vector", call_vec, 8'h18);
    call_ack = 1; step(); call_ack = 0;
    chk("R8 all adpcm flags clear", ctrl_b_q, 8'h00);
    chk("R5 emi clear after adpcm", ctrl_a_q[0], 0);

    finish_run();
  end
endmodule